// File: doc/BRIEF.md
# Character LCD pixel refresh streamer

This block is the core of a small character display controller. A host writes commands and character data over a byte-wide bus with two addresses. The block keeps an 80-entry character store, a 64-byte user glyph store and an address counter. Instead of driving segment and common lines, it sends a frame to a display device. A frame is a window in which the frame marker is high. Inside that window the block sends one 32-bit coordinate word for each lit pixel, and none for unlit pixels.

Refreshes are event driven. The first host write made while nothing is pending arms a single refresh. That refresh fires after a configured number of refresh ticks. While cursor blink is enabled, refreshes keep recurring at that same interval, and the blink phase flips on each one. Layouts of one or two lines of eight cells are supported through parameters, with 8-row or 10-row cells. Commands complete in one cycle, so the busy flag always reads 0.

Top module: `lcd_pixel_streamer`

## Requirements
- R1: After reset, frame_o and pix_valid are 0, and a read at bus_sel=0 returns 0x00.
- R2: A read at bus_sel=0 returns bit 7 = 0 (busy) and bits 6:0 = the address counter.
- R3: A data write (bus_sel=1) stores the byte at the address counter and then advances the counter. In character mode the counter wraps from 79 to 0. In glyph mode it wraps from 63 to 0. A data read returns the addressed byte and advances the counter in the same way.
- R4: Command encodings are as follows. 0x01 fills all 80 character entries with 0x20 and zeroes the counter in character mode. 0x02/0x03 zero the counter in character mode. 0x08|D<<2|C<<1|B sets display, cursor and blink. 0x40|a selects glyph address a. 0x80|a selects character address a, and a value of 80 or more is reduced by 80.
- R5: Command bytes 0x00, 0x04 to 0x07 and 0x10 to 0x3F change no state.
- R6: Suppose no refresh is pending. A host write then arms one. frame_o rises in the cycle after the REFRESH_TICKS-th tick that follows. Further writes before that tick neither restart the count nor add a refresh.
- R7: When a refresh fires with blink enabled, another refresh is armed. When blink is off at the firing, no further refresh happens without a new write.
- R8: frame_o stays high for NUM_LINES*CELL_ROWS*NUM_COLS*5+1 cycles. pix_valid is asserted only inside that window, exactly once per lit pixel, in increasing order of Y*(NUM_COLS*5)+X.
- R9: pix_coord carries X in bits 31:16 and Y in bits 15:0. X = column*5 + pixel column, and Y = line*CELL_ROWS + pixel row. The character at line L, column c sits at address L*40+c.
- R10: Codes 0 to 7 take row r from glyph byte code*8+r, bit 4 being the leftmost pixel, and rows 8 and 9 are blank. Code 0xFF is fully lit. Any other code lights pattern code[4:0] on row code[7:5] only.
- R11: With the cursor on and the counter in character mode, the bottom row of the cell whose address equals the counter is fully lit.
- R12: With blink on, a phase bit toggles at each frame start, and the bit is cleared whenever blink is off. While it is set, the cursor cell is fully lit.
- R13: With the display off, frames still occur but carry no coordinate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | 0 selects the command/status register, 1 selects the data register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (data reads advance the counter) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_sel |
| tick | input | 1 | Refresh interval tick |
| frame_o | output | 1 | High for the duration of a refresh frame |
| pix_valid | output | 1 | Coordinate word strobe |
| pix_coord | output | 32 | X in upper half, Y in lower half |

## Verification
If the address counter is corrupted, the very next status read shows it, and so does the cursor position in the next frame. If a character or glyph store entry is wrong, the error stays hidden until a frame scans it. Each frame is therefore compared pixel by pixel against a model bitmap. Faults in the scheduler show up as a frame edge arriving at the wrong tick, or as a missing or extra frame. The bench counts ticks to the rising frame edge and watches for frames that must not come.

// File: rtl/lps_pkg.sv
package lps_pkg;
    localparam int CELL_W      = 5;
    localparam int DD_DEPTH    = 80;
    localparam int CG_DEPTH    = 64;
    localparam int LINE_STRIDE = 40;
    localparam logic [7:0] BLANK_CODE = 8'h20;

    typedef enum logic [1:0] {SC_IDLE, SC_RUN, SC_END} scan_state_e;

    typedef struct packed {
        logic disp_on;
        logic cur_on;
        logic blink_on;
    } disp_ctl_t;

    typedef struct packed {
        logic [15:0] x;
        logic [15:0] y;
    } coord_t;

    // Glyph row for a code: user glyphs below 8, placeholder table above.
    function automatic logic [4:0] glyph_row(input logic [7:0] code,
                                             input logic [3:0] row,
                                             input logic [7:0] cg_byte);
        if (code < 8'd8)            return (row < 4'd8) ? cg_byte[4:0] : 5'd0;
        else if (code == 8'hFF)     return 5'h1F;
        else if (row == {1'b0, code[7:5]}) return code[4:0];
        else                        return 5'd0;
    endfunction

    function automatic logic [6:0] dd_wrap(input logic [6:0] a);
        return (a >= 7'(DD_DEPTH)) ? a - 7'(DD_DEPTH) : a;
    endfunction
endpackage

// File: rtl/lps_host.sv
module lps_host
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [6:0] ac_o,
    output logic       cg_sel_o,
    output disp_ctl_t  ctl_o,
    input  logic [6:0] dd_raddr,
    output logic [7:0] dd_rdata,
    input  logic [5:0] cg_raddr,
    output logic [7:0] cg_rdata
);
    logic [7:0] ddram [DD_DEPTH];
    logic [7:0] cgram [CG_DEPTH];
    logic [6:0] ac;
    logic       cg_sel;
    disp_ctl_t  ctl;
    logic [6:0] ac_next;

    always_comb begin
        if (cg_sel)                      ac_next = {1'b0, ac[5:0] + 6'd1};
        else if (ac == 7'(DD_DEPTH - 1)) ac_next = 7'd0;
        else                             ac_next = ac + 7'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac     <= '0;
            cg_sel <= 1'b0;
            ctl    <= '0;
            for (int i = 0; i < DD_DEPTH; i++) ddram[i] <= BLANK_CODE;
            for (int i = 0; i < CG_DEPTH; i++) cgram[i] <= '0;
        end else if (wr && !sel) begin
            casez (wdata)
                8'b1???????: begin ac <= dd_wrap(wdata[6:0]); cg_sel <= 1'b0; end
                8'b01??????: begin ac <= {1'b0, wdata[5:0]};  cg_sel <= 1'b1; end
                8'b00001???: ctl <= disp_ctl_t'(wdata[2:0]);
                8'b0000001?: begin ac <= '0; cg_sel <= 1'b0; end
                8'b00000001: begin
                    for (int i = 0; i < DD_DEPTH; i++) ddram[i] <= BLANK_CODE;
                    ac     <= '0;
                    cg_sel <= 1'b0;
                end
                default: ;
            endcase
        end else if (wr && sel) begin
            if (cg_sel) cgram[ac[5:0]] <= wdata;
            else        ddram[ac]      <= wdata;
            ac <= ac_next;
        end else if (rd && sel) begin
            ac <= ac_next;
        end
    end

    always_comb begin
        if (!sel)        rdata = {1'b0, ac};
        else if (cg_sel) rdata = cgram[ac[5:0]];
        else             rdata = ddram[ac];
    end

    assign ac_o     = ac;
    assign cg_sel_o = cg_sel;
    assign ctl_o    = ctl;
    assign dd_rdata = ddram[dd_raddr];
    assign cg_rdata = cgram[cg_raddr];
endmodule

// File: rtl/lps_sched.sv
module lps_sched #(
    parameter int REFRESH_TICKS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic host_wr,
    input  logic tick,
    input  logic blink_on,
    output logic fire
);
    localparam int CW = $clog2(REFRESH_TICKS + 1);

    logic          armed;
    logic [CW-1:0] cnt;

    assign fire = armed && tick && (cnt == CW'(REFRESH_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (fire) begin
            cnt   <= '0;
            armed <= blink_on;
        end else if (host_wr && !armed) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lps_scan.sv
module lps_scan
    import lps_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int CELL_ROWS = 8,
    parameter int NUM_COLS  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  disp_ctl_t   ctl,
    input  logic [6:0]  ac,
    input  logic        cg_sel,
    output logic [6:0]  dd_raddr,
    input  logic [7:0]  dd_rdata,
    output logic [5:0]  cg_raddr,
    input  logic [7:0]  cg_rdata,
    output logic        frame_o,
    output logic        pix_valid,
    output logic [31:0] pix_coord
);
    scan_state_e state;
    logic [7:0]  crow, prow, ccol, pcol;
    logic        phase;
    logic [4:0]  pat;
    logic [2:0]  bit_idx;
    logic        lit, cursor_hit;
    logic        last_pc, last_cc, last_pr, last_cr;
    coord_t      here;

    assign dd_raddr = 7'(int'(crow) * LINE_STRIDE + int'(ccol));
    assign cg_raddr = {dd_rdata[2:0], prow[2:0]};
    assign bit_idx  = 3'(CELL_W - 1) - pcol[2:0];
    assign here.x   = 16'(int'(ccol) * CELL_W + int'(pcol));
    assign here.y   = 16'(int'(crow) * CELL_ROWS + int'(prow));

    assign last_pc = (pcol == 8'(CELL_W - 1));
    assign last_cc = (ccol == 8'(NUM_COLS - 1));
    assign last_pr = (prow == 8'(CELL_ROWS - 1));
    assign last_cr = (crow == 8'(NUM_LINES - 1));

    always_comb begin
        cursor_hit = !cg_sel && (ac == dd_raddr);
        pat = glyph_row(dd_rdata, prow[3:0], cg_rdata);
        if (ctl.cur_on && cursor_hit && last_pr) pat = 5'h1F;
        if (phase && cursor_hit)                 pat = 5'h1F;
        lit = ctl.disp_on && pat[bit_idx];
    end

    always_ff @(posedge clk) begin
        if (rst)                 phase <= 1'b0;
        else if (!ctl.blink_on)  phase <= 1'b0;
        else if (start && state == SC_IDLE) phase <= ~phase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SC_IDLE;
            frame_o   <= 1'b0;
            pix_valid <= 1'b0;
            pix_coord <= '0;
            {crow, prow, ccol, pcol} <= '0;
        end else begin
            unique case (state)
                SC_IDLE: if (start) begin
                    state   <= SC_RUN;
                    frame_o <= 1'b1;
                    {crow, prow, ccol, pcol} <= '0;
                end
                SC_RUN: begin
                    pix_valid <= lit;
                    pix_coord <= here;
                    pcol <= last_pc ? 8'd0 : pcol + 8'd1;
                    if (last_pc) begin
                        ccol <= last_cc ? 8'd0 : ccol + 8'd1;
                        if (last_cc) begin
                            prow <= last_pr ? 8'd0 : prow + 8'd1;
                            if (last_pr) begin
                                crow <= crow + 8'd1;
                                if (last_cr) state <= SC_END;
                            end
                        end
                    end
                end
                SC_END: begin
                    state     <= SC_IDLE;
                    frame_o   <= 1'b0;
                    pix_valid <= 1'b0;
                end
                default: state <= SC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_pixel_streamer.sv
module lcd_pixel_streamer
    import lps_pkg::*;
#(
    parameter int NUM_LINES     = 2,
    parameter int CELL_ROWS     = 8,
    parameter int NUM_COLS      = 8,
    parameter int REFRESH_TICKS = 500
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        tick,
    output logic        frame_o,
    output logic        pix_valid,
    output logic [31:0] pix_coord
);
    logic [6:0] ac, dd_raddr;
    logic [5:0] cg_raddr;
    logic [7:0] dd_rdata, cg_rdata;
    logic       cg_sel, fire;
    disp_ctl_t  ctl;

    lps_host u_host (
        .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .ac_o(ac), .cg_sel_o(cg_sel),
        .ctl_o(ctl), .dd_raddr(dd_raddr), .dd_rdata(dd_rdata),
        .cg_raddr(cg_raddr), .cg_rdata(cg_rdata)
    );

    lps_sched #(.REFRESH_TICKS(REFRESH_TICKS)) u_sched (
        .clk(clk), .rst(rst), .host_wr(bus_wr), .tick(tick),
        .blink_on(ctl.blink_on), .fire(fire)
    );

    lps_scan #(.NUM_LINES(NUM_LINES), .CELL_ROWS(CELL_ROWS), .NUM_COLS(NUM_COLS)) u_scan (
        .clk(clk), .rst(rst), .start(fire), .ctl(ctl), .ac(ac), .cg_sel(cg_sel),
        .dd_raddr(dd_raddr), .dd_rdata(dd_rdata), .cg_raddr(cg_raddr),
        .cg_rdata(cg_rdata), .frame_o(frame_o), .pix_valid(pix_valid),
        .pix_coord(pix_coord)
    );
endmodule

// File: rtl/lps_chk.sv
module lps_chk #(
    parameter int NUM_LINES = 2,
    parameter int CELL_ROWS = 8,
    parameter int NUM_COLS  = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        frame_o,
    input logic        pix_valid,
    input logic [31:0] pix_coord
);
    localparam int W  = NUM_COLS * 5;
    localparam int H  = NUM_LINES * CELL_ROWS;
    localparam int NF = W * H + 1;

    logic [15:0] hi_cnt;
    logic [31:0] idx, last_idx;
    logic        seen;

    assign idx = 32'(pix_coord[15:0]) * 32'(W) + 32'(pix_coord[31:16]);

    always_ff @(posedge clk) begin
        if (rst)          hi_cnt <= '0;
        else if (frame_o) hi_cnt <= hi_cnt + 16'd1;
        else              hi_cnt <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !frame_o) begin
            seen     <= 1'b0;
            last_idx <= '0;
        end else if (pix_valid) begin
            seen     <= 1'b1;
            last_idx <= idx;
        end
    end

    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> frame_o);                                          // R8
    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_o) |-> hi_cnt == 16'(NF));                           // R8
    AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && seen) |-> idx > last_idx);                         // R8
    AST_COORD_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (pix_coord[31:16] < 16'(W) && pix_coord[15:0] < 16'(H))); // R9
    AST_FRAME_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_o) |-> $past(tick));                                 // R6
endmodule

bind lcd_pixel_streamer lps_chk #(
    .NUM_LINES(NUM_LINES), .CELL_ROWS(CELL_ROWS), .NUM_COLS(NUM_COLS)
) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .frame_o(frame_o),
    .pix_valid(pix_valid), .pix_coord(pix_coord)
);

// File: tb/sim_lcd_pixel_streamer.sv
module sim_lcd_pixel_streamer;
    localparam int LINES = 2;
    localparam int CR    = 8;
    localparam int COLS  = 8;
    localparam int P     = 12;
    localparam int W     = COLS * 5;
    localparam int NPIX  = W * LINES * CR;

    logic        clk = 0, rst = 1;
    logic        bus_sel = 0, bus_wr = 0, bus_rd = 0, tick = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        frame_o, pix_valid;
    logic [31:0] pix_coord;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    logic [7:0] mdd [80];
    logic [7:0] mcg [64];
    int  mac = 0;
    bit  mcgm = 0, mD = 0, mC = 0, mB = 0, mph = 0;

    lcd_pixel_streamer #(.NUM_LINES(LINES), .CELL_ROWS(CR), .NUM_COLS(COLS),
                         .REFRESH_TICKS(P)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .frame_o(frame_o), .pix_valid(pix_valid), .pix_coord(pix_coord));

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ac_adv(input int a, input bit cgm);
        if (cgm) return (a + 1) % 64;
        return (a == 79) ? 0 : a + 1;
    endfunction

    task automatic wr_ir(input logic [7:0] b);
        @(negedge clk); bus_sel = 0; bus_wr = 1; bus_wdata = b;
        @(negedge clk); bus_wr = 0;
        if (b[7]) begin mac = (b[6:0] >= 80) ? b[6:0] - 80 : b[6:0]; mcgm = 0; end
        else if (b[6]) begin mac = b[5:0]; mcgm = 1; end
        else if (b[5:4] != 0) ;
        else if (b[3]) begin mD = b[2]; mC = b[1]; mB = b[0]; if (!mB) mph = 0; end
        else if (b[2]) ;
        else if (b[1]) begin mac = 0; mcgm = 0; end
        else if (b[0]) begin for (int i = 0; i < 80; i++) mdd[i] = 8'h20; mac = 0; mcgm = 0; end
    endtask

    task automatic wr_dr(input logic [7:0] b);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_wdata = b;
        @(negedge clk); bus_wr = 0;
        if (mcgm) mcg[mac] = b; else mdd[mac] = b;
        mac = ac_adv(mac, mcgm);
    endtask

    task automatic rd_ir(input string req);
        @(negedge clk); bus_sel = 0; #1;
        check(req, int'(bus_rdata), mac & 8'h7F);
    endtask

    task automatic rd_dr(input string req);
        @(negedge clk); bus_sel = 1; bus_rd = 1; #1;
        check(req, int'(bus_rdata), int'(mcgm ? mcg[mac] : mdd[mac]));
        @(negedge clk); bus_rd = 0;
        mac = ac_adv(mac, mcgm);
    endtask

    function automatic bit exp_lit(input int x, input int y);
        int crow, prow, ccol, pcol, addr;
        logic [7:0] code;
        logic [4:0] pat;
        bit cur;
        crow = y / CR; prow = y % CR; ccol = x / 5; pcol = x % 5;
        addr = crow * 40 + ccol; code = mdd[addr];
        cur = !mcgm && (mac == addr);
        if (!mD) return 0;                                       // R13
        if (mph && cur) return 1;                                // R12
        if (code < 8) pat = (prow < 8) ? mcg[code * 8 + prow][4:0] : 5'd0;  // R10
        else if (code == 8'hFF) pat = 5'h1F;
        else pat = (prow == int'(code[7:5])) ? code[4:0] : 5'd0;
        if (mC && cur && prow == CR - 1) pat = 5'h1F;            // R11
        return pat[4 - pcol];
    endfunction

    task automatic cap_frame(input string req);
        bit expm [NPIX];
        int ecnt = 0, cnt = 0, errs = 0, nhi = 0, last = -1, idx;
        for (int y = 0; y < LINES * CR; y++)
            for (int x = 0; x < W; x++) begin
                expm[y * W + x] = exp_lit(x, y);
                if (expm[y * W + x]) ecnt++;
            end
        while (frame_o === 1'b1 && nhi < 4000) begin
            nhi++;
            if (pix_valid) begin
                idx = int'(pix_coord[15:0]) * W + int'(pix_coord[31:16]);
                if (idx <= last || idx >= NPIX || pix_coord[31:16] >= W) errs++;
                else if (!expm[idx]) errs++;
                last = idx; cnt++;
            end
            @(negedge clk);
        end
        check({req, " R8 frame length"}, nhi, NPIX + 1);
        check({req, " R8 lit count"}, cnt, ecnt);
        check({req, " R9 coordinate match"}, errs, 0);
    endtask

    // pulse up to n ticks; a frame is expected after pulse exp_at (0: none)
    task automatic run_ticks(input int n, input int exp_at, input string req);
        int got = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
            if (frame_o) begin got = i; break; end
        end
        check({req, " R6 ticks to frame"}, got, exp_at);
        if (got > 0) begin
            if (mB) mph = ~mph;
            cap_frame(req);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 frame_o", int'(frame_o), 0);
        check("R1 pix_valid", int'(pix_valid), 0);
        rd_ir("R1 status after reset");
    endtask

    task automatic t_store();
        wr_ir(8'h80);
        wr_dr(8'hFF); wr_dr(8'h00); wr_dr(8'h25); wr_dr(8'h01);
        rd_ir("R2 counter after data writes");
        wr_ir(8'hA8);                 // address 40: line 1, column 0
        wr_dr(8'hE3);
        wr_ir(8'h40);
        wr_dr(8'h11); wr_dr(8'h0A); wr_dr(8'h04); wr_dr(8'h1F);
        wr_dr(8'h04); wr_dr(8'h0A); wr_dr(8'h11); wr_dr(8'h10);
        wr_dr(8'h1E); wr_dr(8'h01);
        rd_ir("R3 glyph counter");
        wr_ir(8'h0C);
        run_ticks(P + 3, P, "R10 glyphs");
    endtask

    task automatic t_wrap();
        wr_ir(8'hCF);                 // 79
        wr_dr(8'h41);
        rd_ir("R3 character wrap");
        wr_ir(8'h7F);                 // glyph 63
        wr_dr(8'h15);
        rd_ir("R3 glyph wrap");
        wr_ir(8'hD2);                 // 82 -> 2
        rd_ir("R4 address reduce");
        rd_dr("R3 data read");
        rd_ir("R3 read advance");
        wr_ir(8'h02);
        rd_ir("R4 home");
        run_ticks(P + 3, P, "R4 after home");
    endtask

    task automatic t_ignored();
        wr_ir(8'h83);
        wr_ir(8'h06); wr_ir(8'h1C); wr_ir(8'h38); wr_ir(8'h00);
        rd_ir("R5 counter kept");
        run_ticks(P + 3, P, "R5 display kept");
    endtask

    task automatic t_sched();
        wr_ir(8'h81);
        run_ticks(P - 1, 0, "R6 early");
        wr_dr(8'h7B);                 // must not restart the count
        run_ticks(3, 1, "R6 no restart");
        run_ticks(P + 2, 0, "R6 single refresh");
    endtask

    task automatic t_cursor();
        wr_ir(8'h0E);
        wr_ir(8'h82);
        run_ticks(P + 3, P, "R11 cursor underline");
    endtask

    task automatic t_blink();
        wr_ir(8'h0F);
        run_ticks(P + 3, P, "R12 phase on");
        run_ticks(P + 3, P, "R7 R12 phase off");
        wr_ir(8'h0E);
        run_ticks(P + 3, P, "R7 last pending");
        run_ticks(P + 3, 0, "R7 stopped");
    endtask

    task automatic t_off();
        wr_ir(8'h0B);
        run_ticks(P + 3, P, "R13 display off");
    endtask

    task automatic t_clear();
        wr_ir(8'h85);
        wr_ir(8'h01);
        rd_ir("R4 clear counter");
        rd_dr("R4 clear fill");
        wr_ir(8'h0C);
        run_ticks(P + 3, P, "R4 cleared frame");
    endtask

    initial begin
        for (int i = 0; i < 80; i++) mdd[i] = 8'h20;
        for (int i = 0; i < 64; i++) mcg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_store();
        t_wrap();
        t_ignored();
        t_sched();
        t_cursor();
        t_blink();
        t_off();
        t_clear();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule